// File: doc/BRIEF.md
# Frame-Paced GPIO Buffer Sequencer

This block decides when a per-frame GPIO mapping step runs inside a converter transfer loop, and it supplies the word that step works on. Each frame has one 32-bit control/data word in shared memory. The words sit in two ping-pong buffers, and the active buffer follows the audio buffer swap.

On every qualifying transfer the block does four things in order. It reads the frame word at its pointer and hands that word to the mapper. It waits for the mapper to finish and writes the returned word back to the same address. It then moves the pointer on by one word. The transfer loop is held off while this runs.

Qualifying transfers are those where service is enabled and the low bits of the transfer counter are all zero. With the default gate width this is one transfer in four.

Top module: `gpio_frame_seq`

## Requirements
- R1: After reset, xfer_ready_o is 1, mem_req_o is 0 and map_start_o is 0. The pointer addresses buffer 0, frame 0, which is byte address BASE_ADDR (0x11000).
- R2: While en_i is 0, an accepted transfer starts no memory access and no mapper run, and xfer_ready_o stays 1.
- R3: A transfer is serviced only when the low GATE_BITS bits of xfer_cnt_i are all zero. The default is 2 bits, so counts 1, 2 and 3 are skipped and count 4 is serviced.
- R4: A buf_start_i pulse accepted while idle sets the pointer to BASE_ADDR when buf_sel_i is 0, or to BASE_ADDR+BUF_OFS (0x400) when it is 1.
- R5: A transfer is accepted in a cycle where xfer_valid_i and xfer_ready_o are both 1. If it is serviced, a read (mem_req_o=1, mem_we_o=0) at the pointer is issued in that same cycle. One cycle later, map_start_o pulses for one cycle and map_word_o carries the read data.
- R6: xfer_ready_o is 0 from the cycle after a serviced transfer until the write-back cycle, inclusive. With a mapper that signals done MAP_LAT cycles after start, that is MAP_LAT+2 cycles.
- R7: In the cycle after map_done_i, the block writes map_result_i (mem_req_o=1, mem_we_o=1) to the same address it read.
- R8: Each write-back moves the pointer on by 4 bytes. Skipped or disabled transfers leave the pointer unchanged.
- R9: After MAX_FRAMES services in one buffer, the pointer wraps to that buffer's frame 0.
- R10: A buf_start_i pulse that arrives while a service is in progress is ignored.
- R11: If buf_start_i and a serviced transfer arrive in the same idle cycle, the read uses the newly selected buffer base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | GPIO service enable |
| xfer_valid_i | input | 1 | A converter transfer is presented |
| xfer_cnt_i | input | CNT_W | Transfer counter value of that transfer |
| buf_start_i | input | 1 | Start of a new buffer |
| buf_sel_i | input | 1 | Buffer-select flag (0 or 1) |
| xfer_ready_o | output | 1 | Transfer loop may proceed |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after a read |
| map_start_o | output | 1 | Mapper start pulse |
| map_word_o | output | DATA_W | Frame word given to the mapper |
| map_done_i | input | 1 | Mapper finished |
| map_result_i | input | DATA_W | Word returned by the mapper |

## Verification
The bench builds the block with MAX_FRAMES set to 8, which brings the per-buffer wrap within a few dozen transfers. It keeps GATE_BITS at 2 and the 0x400 buffer offset at their defaults, so the one-in-four gating and the real buffer-1 addresses are the ones exercised. Its mapper model answers three cycles after start and inverts the upper half of the word. Each write-back is therefore distinguishable from the word that was read.

// File: rtl/gpio_seq_pkg.sv
package gpio_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_MAP  = 2'd2,
    ST_WB   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/svc_gate.sv
module svc_gate #(
  parameter int CNT_W     = 8,
  parameter int GATE_BITS = 2
) (
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] GATE_MASK = CNT_W'((1 << GATE_BITS) - 1);

  assign hit_o = valid_i && en_i && ((cnt_i & GATE_MASK) == '0);
endmodule

// File: rtl/frame_ptr.sv
module frame_ptr #(
  parameter int                ADDR_W     = 32,
  parameter int                MAX_FRAMES = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h11000,
  parameter logic [ADDR_W-1:0] BUF_OFS    = 'h400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int IDX_W      = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1;
  localparam int WORD_SHIFT = 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_FRAMES - 1);

  logic             buf_q;
  logic [IDX_W-1:0] idx_q;
  logic             buf_eff;
  logic [IDX_W-1:0] idx_eff;

  // a load in the same cycle is visible to a read issued in that cycle
  assign buf_eff = load_i ? sel_i : buf_q;
  assign idx_eff = load_i ? '0 : idx_q;
  assign addr_o  = BASE_ADDR + (buf_eff ? BUF_OFS : '0)
                 + (ADDR_W'(idx_eff) << WORD_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= 1'b0;
      idx_q <= '0;
    end else if (load_i) begin
      buf_q <= sel_i;
      idx_q <= '0;
    end else if (adv_i) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  p_hold_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> ($stable(idx_q) && $stable(buf_q)));
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && idx_q == LAST_IDX) |=> (idx_q == '0));
endmodule

// File: rtl/svc_fsm.sv
module svc_fsm
  import gpio_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              map_done_i,
  input  logic [DATA_W-1:0] map_result_i,
  output logic              idle_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic              map_start_o,
  output logic              adv_o,
  output logic [DATA_W-1:0] wb_data_o
);
  seq_state_e  state_q, state_d;
  logic [DATA_W-1:0] wb_q;

  assign idle_o      = (state_q == ST_IDLE);
  assign rd_req_o    = idle_o && hit_i;
  assign map_start_o = (state_q == ST_RD);
  assign wr_req_o    = (state_q == ST_WB);
  assign adv_o       = wr_req_o;
  assign wb_data_o   = wb_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (hit_i)      state_d = ST_RD;
      ST_RD:                   state_d = ST_MAP;
      ST_MAP:  if (map_done_i) state_d = ST_WB;
      ST_WB:                   state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_MAP && map_done_i) wb_q <= map_result_i;
    end
  end

  p_start_after_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> (map_start_o && !idle_o));
  p_wb_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MAP && map_done_i) |=> (wr_req_o && wb_data_o == $past(map_result_i)));
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, wr_req_o, map_start_o}));
endmodule

// File: rtl/gpio_frame_seq.sv
module gpio_frame_seq #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 8,
  parameter int                GATE_BITS  = 2,
  parameter int                MAX_FRAMES = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h11000,
  parameter logic [ADDR_W-1:0] BUF_OFS    = 'h400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              xfer_valid_i,
  input  logic [CNT_W-1:0]  xfer_cnt_i,
  input  logic              buf_start_i,
  input  logic              buf_sel_i,
  output logic              xfer_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              map_start_o,
  output logic [DATA_W-1:0] map_word_o,
  input  logic              map_done_i,
  input  logic [DATA_W-1:0] map_result_i
);
  localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'((1 << GATE_BITS) - 1);

  logic hit, idle, rd_req, wr_req, adv, load;

  svc_gate #(.CNT_W(CNT_W), .GATE_BITS(GATE_BITS)) u_gate (
    .en_i    (en_i),
    .valid_i (xfer_valid_i),
    .cnt_i   (xfer_cnt_i),
    .hit_o   (hit)
  );

  // buffer restarts are only honoured between services
  assign load = buf_start_i && idle;

  frame_ptr #(
    .ADDR_W(ADDR_W), .MAX_FRAMES(MAX_FRAMES),
    .BASE_ADDR(BASE_ADDR), .BUF_OFS(BUF_OFS)
  ) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .sel_i  (buf_sel_i),
    .adv_i  (adv),
    .addr_o (mem_addr_o)
  );

  svc_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .map_done_i   (map_done_i),
    .map_result_i (map_result_i),
    .idle_o       (idle),
    .rd_req_o     (rd_req),
    .wr_req_o     (wr_req),
    .map_start_o  (map_start_o),
    .adv_o        (adv),
    .wb_data_o    (mem_wdata_o)
  );

  assign xfer_ready_o = idle;
  assign mem_req_o    = rd_req || wr_req;
  assign mem_we_o     = wr_req;
  assign map_word_o   = mem_rdata_i;

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (en_i && (xfer_cnt_i & LOW_MASK) == '0));
  p_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && xfer_ready_o) |=> xfer_ready_o);
  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_start_o || mem_we_o) |-> !xfer_ready_o);
  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_ready_o |-> $stable(mem_addr_o));
endmodule

// File: tb/tb_gpio_frame_seq.sv
`timescale 1ns/1ps
module tb_gpio_frame_seq;
  localparam int          CNT_W   = 8;
  localparam int          NFR     = 8;
  localparam int          LAT     = 3;
  localparam logic [31:0] BASE    = 32'h11000;
  localparam logic [31:0] OFS     = 32'h400;
  localparam logic [31:0] MASK    = 32'hFFFF0000;

  logic clk = 0, rst_n = 0;
  logic en = 1, xv = 0, bs = 0, bsel = 0;
  logic [CNT_W-1:0] xc = '0;
  logic ready, mreq, mwe, mstart;
  logic [31:0] maddr, mwdata, mword;
  logic [31:0] mrdata = '0;
  logic mdone;
  logic [31:0] mres;

  always #2 clk = ~clk;

  gpio_frame_seq #(.CNT_W(CNT_W), .MAX_FRAMES(NFR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .xfer_valid_i(xv), .xfer_cnt_i(xc),
    .buf_start_i(bs), .buf_sel_i(bsel), .xfer_ready_o(ready),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .map_start_o(mstart), .map_word_o(mword),
    .map_done_i(mdone), .map_result_i(mres)
  );

  logic [31:0] mem [512];
  logic [31:0] sh  [512];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0, map_in = '0;
  int mcnt = 0;
  int tests = 0, fails = 0, cyc = 0;

  function automatic int widx(input logic [31:0] a);
    return int'((a - BASE) >> 2) & 511;
  endfunction

  always @(posedge clk) begin
    if (mreq && !mwe) begin
      mrdata  <= mem[widx(maddr)];
      rd_cnt  <= rd_cnt + 1;
      rd_addr <= maddr;
    end
    if (mreq && mwe) begin
      mem[widx(maddr)] <= mwdata;
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= maddr;
      wr_data <= mwdata;
    end
    if (mstart) begin
      map_in <= mword;
      mcnt   <= LAT;
    end else if (mcnt != 0) mcnt <= mcnt - 1;
  end
  assign mdone = (mcnt == 1);
  assign mres  = map_in ^ MASK;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle(output int busy);
    busy = 0;
    @(negedge clk);
    while (!ready) begin busy++; @(negedge clk); end
  endtask

  // one serviced transfer, optionally with a buffer restart in the same cycle
  task automatic service(input logic [CNT_W-1:0] cnt, input bit ld, input bit sel,
                         input logic [31:0] exp_addr, input string tag);
    int r0, busy, k;
    r0 = rd_cnt;
    @(negedge clk);
    xv = 1; xc = cnt; bs = ld; bsel = sel;
    @(negedge clk);
    xv = 0; bs = 0;
    busy = 1;
    while (!ready) begin busy++; @(negedge clk); end
    busy--;
    k = widx(exp_addr);
    chk(rd_cnt == r0 + 1, {tag, " one read"}, rd_cnt - r0, 1);
    chk(rd_addr == exp_addr, {tag, " read addr"}, rd_addr, exp_addr);
    chk(wr_addr == exp_addr, {tag, " R7 write addr"}, wr_addr, exp_addr);
    chk(map_in == sh[k], {tag, " R5 mapper word"}, map_in, sh[k]);
    chk(wr_data == (sh[k] ^ MASK), {tag, " R7 write data"}, wr_data, sh[k] ^ MASK);
    chk(busy == LAT + 2, {tag, " R6 stall cycles"}, busy, LAT + 2);
    sh[k] = sh[k] ^ MASK;
  endtask

  task automatic skip(input logic [CNT_W-1:0] cnt, input string tag);
    int r0, w0, busy;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    xv = 1; xc = cnt;
    wait_idle(busy);
    xv = 0;
    @(negedge clk);
    chk(rd_cnt == r0 && wr_cnt == w0 && busy == 0, tag, rd_cnt - r0, 0);
  endtask

  task automatic t_reset();
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    chk(mreq == 1'b0, "R1 no mem req after reset", mreq, 0);
    chk(mstart == 1'b0, "R1 no map start after reset", mstart, 0);
  endtask

  task automatic t_basic();
    service(0, 0, 0, BASE, "R1 R5 first frame");
    service(0, 0, 0, BASE + 4, "R8 advance");
  endtask

  task automatic t_gate();
    skip(1, "R3 cnt1 skipped");
    skip(2, "R3 cnt2 skipped");
    skip(3, "R3 cnt3 skipped");
    service(4, 0, 0, BASE + 8, "R3 R8 cnt4 serviced");
  endtask

  task automatic t_disable();
    en = 0;
    skip(0, "R2 disabled");
    skip(8, "R2 disabled");
    en = 1;
    service(0, 0, 0, BASE + 12, "R8 pointer kept over skips");
  endtask

  task automatic t_bufsel();
    @(negedge clk); bs = 1; bsel = 1;
    @(negedge clk); bs = 0;
    service(0, 0, 0, BASE + OFS, "R4 buffer1 base");
    service(0, 1, 0, BASE, "R11 R4 same-cycle load buffer0");
  endtask

  task automatic t_busy_load();
    int busy;
    @(negedge clk);
    xv = 1; xc = 0;
    @(negedge clk);
    xv = 0; bs = 1; bsel = 1;
    @(negedge clk);
    bs = 0;
    wait_idle(busy);
    sh[widx(BASE + 4)] = sh[widx(BASE + 4)] ^ MASK;
    chk(wr_addr == BASE + 4, "R10 service during load", wr_addr, BASE + 4);
    service(0, 0, 0, BASE + 8, "R10 load while busy ignored");
  endtask

  task automatic t_wrap();
    service(0, 1, 1, BASE + OFS, "R9 wrap frame0");
    for (int i = 1; i < NFR; i++)
      service(0, 0, 0, BASE + OFS + 32'(i * 4), "R9 wrap walk");
    service(0, 0, 0, BASE + OFS, "R9 wrapped to base");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 32'hC0DE0000 + 32'(i);
      sh[i]  = 32'hC0DE0000 + 32'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gate();
    t_disable();
    t_bufsel();
    t_busy_load();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule